// File: doc/BRIEF.md
# Two-Wire Bus Clock Waveform Generator

This block times the clock line of a two-wire serial bus master. A configuration word holds three fields: a count for the low phase, a count for the high phase and a prescale exponent. Each phase lasts the count scaled by two to the power of the exponent, plus a fixed offset of peripheral clocks. With equal counts the bus clock runs at the peripheral clock divided by twice one phase length.

The generator drives `scl_out`, where 1 means the line is released and 0 means it is pulled low. It pulses `phase_stb` in the first cycle of every phase, so the byte engine can act on each clock edge. It also pulses `sda_stb` a programmable hold time after the clock falls, which marks when the data line may change. A stall input freezes the timing while a target stretches the clock. A low enable releases the line and clears all timing.

These pins are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `i2c_clkgen`

## Requirements
- R1: While `en` is high, phases alternate and the first phase after enabling is low. Each phase keeps `scl_out` constant for (count << exponent) + 4 cycles, and `phase_stb` is high for exactly the first cycle of each phase.
- R2: Configuration word fields: low-phase count in bits [7:0], high-phase count in bits [15:8], exponent in bits [18:16].
- R3: An exponent above 6 acts as 6.
- R4: `sda_stb` is a single-cycle pulse that occurs only while `scl_out` is low. It appears in cycle H of the low phase, counting the first low cycle as cycle 0, where H = hold + 3.
- R5: A hold value above 40 acts as 40, so H never exceeds 43.
- R6: If H is not smaller than the low-phase length, `sda_stb` appears in the last cycle of the low phase.
- R7: The configuration word and hold value are sampled only at the clock edge that starts a low phase. A value present in the last cycle of a high phase therefore governs the next low and high phases, and changes at any other time leave the running period unchanged.
- R8: Each cycle with `stall` high freezes the phase counter. The current phase is extended by one cycle, with no `scl_out` change and no `phase_stb`.
- R9: With `en` low, from the next cycle `scl_out` is 1 and both strobes are 0. Re-enabling starts a full low phase.
- R10: After reset `scl_out` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable; low releases the clock line and clears timing |
| cfg_word | input | 19 | Low count [7:0], high count [15:8], exponent [18:16] |
| hold_cnt | input | 8 | Requested data hold value, clamped to 40 |
| stall | input | 1 | Freezes the phase counter while high |
| scl_out | output | 1 | Clock line: 1 released, 0 driven low |
| phase_stb | output | 1 | One-cycle pulse in the first cycle of each phase |
| sda_stb | output | 1 | One-cycle pulse when the data line may change |

## Verification
Two collisions are provoked on purpose. In the first, the configuration word is replaced in the very last cycle of a high phase, so the sampling edge and the phase turnover fall in the same cycle. The new low and high lengths must then be measured from the next phase onward. In the second, a stall covers the cycles around the hold point and the phase end, and the phase length must grow by exactly the number of stalled cycles while the clock level stays put. Lengths are judged by counting cycles between successive `phase_stb` pulses at the ports.

// File: rtl/i2c_clkgen_pkg.sv
package i2c_clkgen_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  localparam int unsigned SDA_BASE_DELAY = 3;

endpackage

// File: rtl/i2c_clkgen_len.sv
module i2c_clkgen_len #(
  parameter int CNT_W  = 8,
  parameter int EXP_W  = 3,
  parameter int LEN_W  = 15,
  parameter int OFFSET = 4
) (
  input  logic [CNT_W-1:0] count,
  input  logic [EXP_W-1:0] expo,
  output logic [LEN_W-1:0] len
);
  // scaled count plus the fixed per-phase overhead
  always_comb begin
    len = (LEN_W'(count) << expo) + LEN_W'(OFFSET);
  end
endmodule

// File: rtl/i2c_clkgen_shadow.sv
module i2c_clkgen_shadow
  import i2c_clkgen_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int EXP_W    = 3,
  parameter int EXP_MAX  = 6,
  parameter int OFFSET   = 4,
  parameter int HOLD_W   = 8,
  parameter int HOLD_MAX = 40,
  parameter int LEN_W    = 15,
  localparam int CFG_W   = 2 * CNT_W + EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [HOLD_W-1:0] hold_cnt,
  output logic [LEN_W-1:0] lo_len,
  output logic [LEN_W-1:0] hi_len,
  output logic [LEN_W-1:0] hold_pos
);
  logic [EXP_W-1:0]  exp_raw;
  logic [EXP_W-1:0]  exp_eff;
  logic [LEN_W-1:0]  new_len [2];
  logic [HOLD_W-1:0] hold_sat;
  logic [LEN_W-1:0]  hold_req;
  logic [LEN_W-1:0]  hold_new;

  assign exp_raw = cfg_word[2*CNT_W +: EXP_W];
  assign exp_eff = (exp_raw > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_raw;

  // index 0: low phase, index 1: high phase
  for (genvar g = 0; g < 2; g++) begin : g_len
    i2c_clkgen_len #(
      .CNT_W (CNT_W),
      .EXP_W (EXP_W),
      .LEN_W (LEN_W),
      .OFFSET(OFFSET)
    ) u_len (
      .count(cfg_word[g*CNT_W +: CNT_W]),
      .expo (exp_eff),
      .len  (new_len[g])
    );
  end

  always_comb begin
    hold_sat = (hold_cnt > HOLD_W'(HOLD_MAX)) ? HOLD_W'(HOLD_MAX) : hold_cnt;
    hold_req = LEN_W'(hold_sat) + LEN_W'(SDA_BASE_DELAY);
    // the data strobe must land inside the low phase
    hold_new = (hold_req >= new_len[0]) ? (new_len[0] - LEN_W'(1)) : hold_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len   <= LEN_W'(OFFSET);
      hi_len   <= LEN_W'(OFFSET);
      hold_pos <= LEN_W'(SDA_BASE_DELAY);
    end else if (load) begin
      lo_len   <= new_len[0];
      hi_len   <= new_len[1];
      hold_pos <= hold_new;
    end
  end
endmodule

// File: rtl/i2c_clkgen_timer.sv
module i2c_clkgen_timer
  import i2c_clkgen_pkg::*;
#(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             stall,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [LEN_W-1:0] hi_len,
  output logic             load,
  output logic             low_step,
  output logic [LEN_W-1:0] cnt_o,
  output logic             scl_out,
  output logic             phase_stb
);
  phase_e           phase;
  logic             active;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] cur_len;
  logic             last;
  logic             run;

  always_comb begin
    cur_len  = (phase == PH_LOW) ? lo_len : hi_len;
    last     = (cnt == cur_len - LEN_W'(1));
    run      = active && en && !stall;
    load     = en && (!active || (run && phase == PH_HIGH && last));
    low_step = run && (phase == PH_LOW) && !last;
    cnt_o    = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      phase     <= PH_LOW;
      cnt       <= '0;
      scl_out   <= 1'b1;
      phase_stb <= 1'b0;
    end else if (!en) begin
      active    <= 1'b0;
      phase     <= PH_LOW;
      cnt       <= '0;
      scl_out   <= 1'b1;
      phase_stb <= 1'b0;
    end else if (!active) begin
      active    <= 1'b1;
      phase     <= PH_LOW;
      cnt       <= '0;
      scl_out   <= 1'b0;
      phase_stb <= 1'b1;
    end else if (run && last) begin
      phase     <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
      cnt       <= '0;
      scl_out   <= (phase == PH_LOW);
      phase_stb <= 1'b1;
    end else begin
      phase_stb <= 1'b0;
      if (run) cnt <= cnt + LEN_W'(1);
    end
  end
endmodule

// File: rtl/i2c_clkgen_hold.sv
module i2c_clkgen_hold #(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_step,
  input  logic [LEN_W-1:0] cnt,
  input  logic [LEN_W-1:0] hold_pos,
  output logic             sda_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_stb <= 1'b0;
    else        sda_stb <= low_step && ((cnt + LEN_W'(1)) == hold_pos);
  end
endmodule

// File: rtl/i2c_clkgen.sv
module i2c_clkgen #(
  parameter int CNT_W    = 8,
  parameter int EXP_W    = 3,
  parameter int EXP_MAX  = 6,
  parameter int OFFSET   = 4,
  parameter int HOLD_W   = 8,
  parameter int HOLD_MAX = 40,
  localparam int CFG_W   = 2 * CNT_W + EXP_W,
  localparam int MAX_LEN = (((1 << CNT_W) - 1) << EXP_MAX) + OFFSET,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic [HOLD_W-1:0] hold_cnt,
  input  logic              stall,
  output logic              scl_out,
  output logic              phase_stb,
  output logic              sda_stb
);
  logic             load;
  logic             low_step;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lo_len;
  logic [LEN_W-1:0] hi_len;
  logic [LEN_W-1:0] hold_pos;

  i2c_clkgen_shadow #(
    .CNT_W   (CNT_W),
    .EXP_W   (EXP_W),
    .EXP_MAX (EXP_MAX),
    .OFFSET  (OFFSET),
    .HOLD_W  (HOLD_W),
    .HOLD_MAX(HOLD_MAX),
    .LEN_W   (LEN_W)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .cfg_word(cfg_word),
    .hold_cnt(hold_cnt),
    .lo_len  (lo_len),
    .hi_len  (hi_len),
    .hold_pos(hold_pos)
  );

  i2c_clkgen_timer #(
    .LEN_W(LEN_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .stall    (stall),
    .lo_len   (lo_len),
    .hi_len   (hi_len),
    .load     (load),
    .low_step (low_step),
    .cnt_o    (cnt),
    .scl_out  (scl_out),
    .phase_stb(phase_stb)
  );

  i2c_clkgen_hold #(
    .LEN_W(LEN_W)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .low_step(low_step),
    .cnt     (cnt),
    .hold_pos(hold_pos),
    .sda_stb (sda_stb)
  );
endmodule

// File: rtl/i2c_clkgen_chk.sv
module i2c_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic stall,
  input logic scl_out,
  input logic phase_stb,
  input logic sda_stb
);
  // R1: every level change of the clock line is flagged by the phase strobe
  a_r1_toggle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (scl_out != $past(scl_out))) |-> phase_stb);

  // R1: the phase strobe lasts a single cycle
  a_r1_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    phase_stb |=> !phase_stb);

  // R4: the data strobe only occurs with the clock line low
  a_r4_sda_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_stb |-> !scl_out);

  // R4: the data strobe lasts a single cycle
  a_r4_sda_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sda_stb |=> !sda_stb);

  // R8: a stalled cycle never moves the clock line
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stall && $past(en)) |=> ($stable(scl_out) && !phase_stb));

  // R9: disabled generator releases the line and stays quiet
  a_r9_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_out && !phase_stb && !sda_stb));
endmodule

bind i2c_clkgen i2c_clkgen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .stall    (stall),
  .scl_out  (scl_out),
  .phase_stb(phase_stb),
  .sda_stb  (sda_stb)
);

// File: tb/i2c_clkgen_test.sv
module i2c_clkgen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [18:0] cfg_word = '0;
  logic [7:0]  hold_cnt = '0;
  logic        stall = 1'b0;
  logic        scl_out;
  logic        phase_stb;
  logic        sda_stb;

  int n_checks = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_clkgen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cfg_word (cfg_word),
    .hold_cnt (hold_cnt),
    .stall    (stall),
    .scl_out  (scl_out),
    .phase_stb(phase_stb),
    .sda_stb  (sda_stb)
  );

  function automatic logic [18:0] mk(input int lo, input int hi, input int ex);
    return {ex[2:0], hi[7:0], lo[7:0]};
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // enable from a disabled state; returns at the first low cycle
  task automatic start(input logic [18:0] c, input logic [7:0] h);
    en = 1'b0;
    cfg_word = c;
    hold_cnt = h;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check_int("R1", "start strobe", int'(phase_stb), 1);
    check_int("R1", "start level", int'(scl_out), 0);
  endtask

  // called in cycle 0 of a phase; returns in cycle 0 of the next one
  task automatic measure(input int stall_at, input int stall_n, input int chg_at,
                         input logic [18:0] chg_cfg, output int len,
                         output int lvl, output int sda_at);
    len = 0;
    lvl = int'(scl_out);
    sda_at = -1;
    forever begin
      if (sda_stb && sda_at < 0) sda_at = len;
      if (len == chg_at) cfg_word = chg_cfg;
      stall = (len >= stall_at) && (len < stall_at + stall_n);
      len++;
      @(negedge clk);
      if (phase_stb || len > 20000) break;
    end
    stall = 1'b0;
  endtask

  task automatic t_reset;
    check_int("R10", "reset scl", int'(scl_out), 1);
    check_int("R10", "reset phase_stb", int'(phase_stb), 0);
    check_int("R10", "reset sda_stb", int'(sda_stb), 0);
  endtask

  task automatic t_basic;
    int len, lvl, sa;
    start(mk(5, 3, 0), 8'd0);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R1", "basic low len", len, 9);
    check_int("R1", "basic low level", lvl, 0);
    check_int("R4", "basic sda pos", sa, 3);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R2", "basic high len", len, 7);
    check_int("R1", "basic high level", lvl, 1);
    check_int("R4", "no sda in high", sa, -1);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R1", "basic second low len", len, 9);
  endtask

  task automatic t_prescale;
    int len, lvl, sa;
    start(mk(2, 1, 2), 8'd1);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R2", "prescale low len", len, 12);
    check_int("R4", "prescale sda pos", sa, 4);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R2", "prescale high len", len, 8);
  endtask

  task automatic t_exp_clamp;
    int len, lvl, sa;
    start(mk(1, 2, 7), 8'd0);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R3", "clamped exp low len", len, 68);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R3", "clamped exp high len", len, 132);
  endtask

  task automatic t_hold_clamp;
    int len, lvl, sa;
    start(mk(20, 0, 2), 8'd100);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R5", "hold clamp low len", len, 84);
    check_int("R5", "hold clamp sda pos", sa, 43);
  endtask

  task automatic t_hold_long;
    int len, lvl, sa;
    start(mk(0, 0, 0), 8'd10);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R6", "short low len", len, 4);
    check_int("R6", "sda at last low cycle", sa, 3);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R6", "short high len", len, 4);
  endtask

  task automatic t_cfg_late;
    int len, lvl, sa;
    start(mk(5, 3, 0), 8'd0);
    measure(-1, 0, 2, mk(10, 10, 0), len, lvl, sa);
    check_int("R7", "low after mid change", len, 9);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R7", "high keeps old cfg", len, 7);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R7", "next low takes new cfg", len, 14);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R7", "next high takes new cfg", len, 14);
  endtask

  task automatic t_cfg_boundary;
    int len, lvl, sa;
    start(mk(5, 3, 0), 8'd0);
    measure(-1, 0, -1, '0, len, lvl, sa);
    measure(-1, 0, 6, mk(1, 1, 1), len, lvl, sa);
    check_int("R7", "high with change in last cycle", len, 7);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R7", "boundary change low len", len, 6);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R7", "boundary change high len", len, 6);
  endtask

  task automatic t_stall;
    int len, lvl, sa;
    start(mk(5, 3, 0), 8'd0);
    measure(1, 5, -1, '0, len, lvl, sa);
    check_int("R8", "stalled low len", len, 14);
    check_int("R8", "stalled sda pos", sa, 8);
    measure(5, 3, -1, '0, len, lvl, sa);
    check_int("R8", "stall over high end len", len, 10);
    check_int("R8", "level after stalled high", int'(scl_out), 0);
  endtask

  task automatic t_disable;
    int len, lvl, sa;
    start(mk(5, 3, 0), 8'd0);
    measure(-1, 0, -1, '0, len, lvl, sa);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check_int("R9", "disabled scl", int'(scl_out), 1);
    check_int("R9", "disabled phase_stb", int'(phase_stb), 0);
    @(negedge clk);
    check_int("R9", "still released", int'(scl_out), 1);
    en = 1'b1;
    @(negedge clk);
    check_int("R9", "restart strobe", int'(phase_stb), 1);
    check_int("R9", "restart low", int'(scl_out), 0);
    measure(-1, 0, -1, '0, len, lvl, sa);
    check_int("R9", "full low after restart", len, 9);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_exp_clamp();
    t_hold_clamp();
    t_hold_long();
    t_cfg_late();
    t_cfg_boundary();
    t_stall();
    t_disable();
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule